// File: doc/BRIEF.md
# Selectable-Order Tanlock Loop Filter

This block is the digital loop filter that sits between the arctangent phase detector and the digitally controlled oscillator of a tanlock loop. It accepts a signed phase-error sample together with a valid strobe and produces a signed correction word that the oscillator subtracts from its nominal period. The filter is clocked by the double-rate oscillator ticks, so it takes a new error sample at twice the loop's free-running rate. A correction computed for sample k is meant to shape the oscillator interval that follows, which gives the loop its one-sample feedback delay.

Two filter orders are available. In first order the correction is a proportional term: the error scaled by a gain. In second order, a running sum of the error scaled by a second gain is added to that proportional term, which implements G1 + G2/(1 − z⁻¹). Both gains are unsigned fractions with 15 fractional bits, supplied as runtime inputs. The running sum and the correction both clamp at their signed limits instead of wrapping. The order is latched only while the synchronous clear is high, so a loop in lock cannot change order by accident.

Top module: `tanlock_loop_filter`

## Requirements
- R1: After reset, corr is 0, corr_valid is 0, the filter is in first order and its running sum is 0.
- R2: Every err_valid pulse that is not cancelled by clr yields exactly one corr_valid pulse two clock cycles later; samples may arrive on consecutive cycles.
- R3: In first order (order_sel latched as 0), corr = floor(err × gain_p / 2^15), clamped to the signed range of corr.
- R4: In second order (order_sel latched as 1), the running sum becomes S(k) = S(k−1) + floor(err × gain_i / 2^15), and corr = floor(err × gain_p / 2^15) + S(k), clamped to the signed range of corr.
- R5: The running sum clamps at 2^(ACC_W−1)−1 and −2^(ACC_W−1), never wraps, and moves away from a limit on the next sample of opposite sign.
- R6: When the sum of the two paths exceeds the range of corr, corr holds the nearest signed limit.
- R7: A cycle with clr high zeroes the running sum and corr, drops corr_valid on the next cycle, and discards any sample in flight, including one presented in the same cycle.
- R8: order_sel is read only in a cycle with clr high; changing it at any other time leaves the filter order unchanged.
- R9: Between corr_valid pulses corr keeps its last value; err and the gains are ignored in cycles where err_valid is low.
- R10: The gains used for a sample are those present in the cycle in which its err_valid is high; the gains may change from one sample to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate oscillator tick clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of running sum and output; latches order_sel |
| order_sel | input | 1 | Filter order: 0 proportional, 1 proportional plus running sum |
| gain_p | input | GAIN_W | Proportional gain, unsigned, GAIN_FRAC fractional bits |
| gain_i | input | GAIN_W | Running-sum gain, unsigned, GAIN_FRAC fractional bits |
| err_valid | input | 1 | Phase-error sample strobe |
| err | input | ERR_W | Signed phase-error sample |
| corr_valid | output | 1 | Correction strobe, two cycles after err_valid |
| corr | output | OUT_W | Signed saturated period correction |

## Verification
The bench builds the filter with ACC_W = 20 and OUT_W = 18 and keeps the 16-bit error and gain widths. A 20-bit running sum fed with near full-scale steps of about 65 534 reaches both of its limits within roughly a dozen samples, and an 18-bit output can be driven past its range by the proportional term plus a saturated sum, so both clamps are exercised in a short run. The floor behaviour of the fractional scaling is probed with small negative errors and half-scale gains.

// File: rtl/tll_pkg.sv
package tll_pkg;
  typedef enum logic {
    ORD_FIRST  = 1'b0,
    ORD_SECOND = 1'b1
  } tll_order_e;
endpackage

// File: rtl/tll_gain_mult.sv
module tll_gain_mult #(
  parameter int ERR_W     = 16,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 15,
  parameter int PROD_W    = ERR_W + GAIN_W + 1 - GAIN_FRAC
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic signed [ERR_W-1:0]  err,
  input  logic        [GAIN_W-1:0] gain,
  output logic signed [PROD_W-1:0] prod_q
);
  localparam int FULL_W = ERR_W + GAIN_W + 1;

  logic signed [FULL_W-1:0] err_ext;
  logic signed [FULL_W-1:0] gain_ext;
  logic signed [FULL_W-1:0] full_prod;
  logic signed [FULL_W-1:0] scaled;

  always_comb begin
    err_ext   = {{(GAIN_W+1){err[ERR_W-1]}}, err};
    gain_ext  = {{(ERR_W+1){1'b0}}, gain};
    full_prod = err_ext * gain_ext;
    scaled    = full_prod >>> GAIN_FRAC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
    end else if (load) begin
      prod_q <= scaled[PROD_W-1:0];
    end
  end
endmodule

// File: rtl/tll_accum.sv
module tll_accum #(
  parameter int ACC_W = 32,
  parameter int INC_W = 18
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    en,
  input  logic signed [INC_W-1:0] inc,
  output logic signed [ACC_W-1:0] acc_q,
  output logic signed [ACC_W-1:0] acc_nx
);
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W:0] wide_sum;

  always_comb begin
    wide_sum = {acc_q[ACC_W-1], acc_q} + {{(ACC_W+1-INC_W){inc[INC_W-1]}}, inc};
    if (wide_sum[ACC_W] != wide_sum[ACC_W-1]) begin
      acc_nx = wide_sum[ACC_W] ? ACC_MIN : ACC_MAX;
    end else begin
      acc_nx = wide_sum[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
    end else if (en) begin
      acc_q <= acc_nx;
    end
  end

  // R5
  acc_pos_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && !acc_q[ACC_W-1] && !inc[INC_W-1]) |=> !acc_q[ACC_W-1]);

  // R5
  acc_neg_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && acc_q[ACC_W-1] && inc[INC_W-1]) |=> acc_q[ACC_W-1]);

  // R7
  acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc_q == '0));
endmodule

// File: rtl/tll_out_stage.sv
module tll_out_stage #(
  parameter int PROD_W = 18,
  parameter int ACC_W  = 32,
  parameter int OUT_W  = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     v_in,
  input  logic                     use_sum,
  input  logic signed [PROD_W-1:0] prop,
  input  logic signed [ACC_W-1:0]  integ,
  output logic signed [OUT_W-1:0]  corr,
  output logic                     corr_valid
);
  localparam int SUM_W = ((ACC_W > PROD_W) ? ACC_W : PROD_W) + 1;
  localparam logic signed [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [SUM_W-1:0] total;
  logic signed [OUT_W-1:0] clamped;

  always_comb begin
    total = {{(SUM_W-PROD_W){prop[PROD_W-1]}}, prop};
    if (use_sum) begin
      total = total + {{(SUM_W-ACC_W){integ[ACC_W-1]}}, integ};
    end
  end

  generate
    if (SUM_W > OUT_W) begin : g_clamp
      logic [SUM_W-OUT_W:0] top_bits;
      always_comb begin
        top_bits = total[SUM_W-1:OUT_W-1];
        if (top_bits == '0 || top_bits == '1) begin
          clamped = total[OUT_W-1:0];
        end else begin
          clamped = total[SUM_W-1] ? OUT_MIN : OUT_MAX;
        end
      end
    end else begin : g_extend
      always_comb begin
        clamped = OUT_W'(total);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      corr       <= '0;
      corr_valid <= 1'b0;
    end else begin
      corr_valid <= v_in;
      if (v_in) begin
        corr <= clamped;
      end
    end
  end

  // R9
  corr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!v_in && !clr) |=> $stable(corr));

  // R7
  out_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (corr == '0 && !corr_valid));
endmodule

// File: rtl/tanlock_loop_filter.sv
module tanlock_loop_filter
  import tll_pkg::*;
#(
  parameter int ERR_W     = 16,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 15,
  parameter int ACC_W     = 32,
  parameter int OUT_W     = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     order_sel,
  input  logic        [GAIN_W-1:0] gain_p,
  input  logic        [GAIN_W-1:0] gain_i,
  input  logic                     err_valid,
  input  logic signed [ERR_W-1:0]  err,
  output logic                     corr_valid,
  output logic signed [OUT_W-1:0]  corr
);
  localparam int PROD_W = ERR_W + GAIN_W + 1 - GAIN_FRAC;
  localparam int N_PATH = 2;

  tll_order_e order_q;
  logic       stage1_v;
  logic       take;
  logic       acc_en;

  logic        [GAIN_W-1:0] gains [N_PATH];
  logic signed [PROD_W-1:0] prods [N_PATH];
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [ACC_W-1:0]  acc_nx;

  assign take     = err_valid && !clr;
  assign gains[0] = gain_p;
  assign gains[1] = gain_i;
  assign acc_en   = stage1_v && (order_q == ORD_SECOND);

  always_ff @(posedge clk) begin
    if (rst) begin
      order_q <= ORD_FIRST;
    end else if (clr) begin
      order_q <= tll_order_e'(order_sel);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      stage1_v <= 1'b0;
    end else begin
      stage1_v <= take;
    end
  end

  generate
    for (genvar p = 0; p < N_PATH; p++) begin : g_path
      tll_gain_mult #(
        .ERR_W    (ERR_W),
        .GAIN_W   (GAIN_W),
        .GAIN_FRAC(GAIN_FRAC),
        .PROD_W   (PROD_W)
      ) u_mult (
        .clk   (clk),
        .rst   (rst),
        .load  (take),
        .err   (err),
        .gain  (gains[p]),
        .prod_q(prods[p])
      );
    end
  endgenerate

  tll_accum #(
    .ACC_W(ACC_W),
    .INC_W(PROD_W)
  ) u_accum (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .en    (acc_en),
    .inc   (prods[1]),
    .acc_q (acc_q),
    .acc_nx(acc_nx)
  );

  tll_out_stage #(
    .PROD_W(PROD_W),
    .ACC_W (ACC_W),
    .OUT_W (OUT_W)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .v_in      (stage1_v),
    .use_sum   (order_q == ORD_SECOND),
    .prop      (prods[0]),
    .integ     (acc_nx),
    .corr      (corr),
    .corr_valid(corr_valid)
  );

  // R2
  latency_two_chk: assert property (@(posedge clk) disable iff (rst)
    (err_valid && !clr) ##1 !clr |=> corr_valid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (!err_valid || clr) ##1 1'b1 |=> !corr_valid);

  // R8
  order_locked_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> $stable(order_q));

  // R3
  first_order_sum_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (order_q == ORD_FIRST) |-> (acc_q == '0));
endmodule

// File: tb/tanlock_loop_filter_tb.sv
module tanlock_loop_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ERR_W  = 16;
  localparam int GAIN_W = 16;
  localparam int FRAC   = 15;
  localparam int ACC_W  = 20;
  localparam int OUT_W  = 18;
  localparam longint ACC_HI = (64'sd1 <<< (ACC_W-1)) - 1;
  localparam longint ACC_LO = -(64'sd1 <<< (ACC_W-1));
  localparam longint OUT_HI = (64'sd1 <<< (OUT_W-1)) - 1;
  localparam longint OUT_LO = -(64'sd1 <<< (OUT_W-1));

  typedef struct {
    longint val;
    string  req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic order_sel = 1'b0;
  logic [GAIN_W-1:0] gain_p = '0;
  logic [GAIN_W-1:0] gain_i = '0;
  logic err_valid = 1'b0;
  logic signed [ERR_W-1:0] err = '0;
  logic corr_valid;
  logic signed [OUT_W-1:0] corr;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  exp_t sb_q[$];
  longint m_acc = 0;
  bit m_second = 1'b0;
  longint last_corr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tanlock_loop_filter #(
    .ERR_W(ERR_W), .GAIN_W(GAIN_W), .GAIN_FRAC(FRAC), .ACC_W(ACC_W), .OUT_W(OUT_W)
  ) u_dut (
    .clk(clk), .rst(rst), .clr(clr), .order_sel(order_sel),
    .gain_p(gain_p), .gain_i(gain_i), .err_valid(err_valid), .err(err),
    .corr_valid(corr_valid), .corr(corr)
  );

  function automatic longint clampv(longint v, longint lo, longint hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic longint scale(longint e, longint g);
    return (e * g) >>> FRAC;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp_v);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic send(int e, int gp, int gi, string req);
    exp_t it;
    longint pv;
    err       = ERR_W'(e);
    gain_p    = GAIN_W'(gp);
    gain_i    = GAIN_W'(gi);
    err_valid = 1'b1;
    pv = scale(longint'(e), longint'(gp));
    if (m_second) begin
      m_acc = clampv(m_acc + scale(longint'(e), longint'(gi)), ACC_LO, ACC_HI);
      pv = pv + m_acc;
    end
    it.val = clampv(pv, OUT_LO, OUT_HI);
    it.req = req;
    sb_q.push_back(it);
    @(negedge clk);
    err_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_clr(bit sel);
    drain();
    clr = 1'b1;
    order_sel = sel;
    @(negedge clk);
    clr = 1'b0;
    m_acc = 0;
    m_second = sel;
    check(corr == '0, "R7 corr zero after clr", corr, 0);
    check(corr_valid == 1'b0, "R7 valid low after clr", corr_valid, 0);
  endtask

  always @(negedge clk) begin
    if (!rst && corr_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R2 unexpected corr_valid", 1, 0);
      end else begin
        exp_t it;
        it = sb_q.pop_front();
        check(longint'(corr) == it.val, it.req, corr, it.val);
      end
      last_corr = corr;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(corr == '0, "R1 corr after reset", corr, 0);
    check(corr_valid == 1'b0, "R1 corr_valid after reset", corr_valid, 0);

    // R3 first order, back-to-back samples (R2), floor behaviour
    send(1000, 'h8000, 'h8000, "R3 half gain positive");
    send(-1000, 'h8000, 0, "R3 half gain negative");
    send(-3, 'h4000, 0, "R3 floor negative fraction");
    send(32767, 'hFFFF, 'hFFFF, "R3 full scale positive");
    send(-32768, 'hFFFF, 0, "R3 full scale negative");
    send(12345, 'h1234, 'h7777, "R10 per-sample gain");
    drain();
    check(sb_q.size() == 0, "R2 all samples answered", sb_q.size(), 0);

    // R8 order_sel without clr is ignored
    order_sel = 1'b1;
    repeat (2) @(negedge clk);
    send(2000, 'h8000, 'h8000, "R8 order unchanged without clr");
    send(2000, 'h8000, 'h8000, "R8 order unchanged second sample");
    drain();

    // R4 second order
    do_clr(1'b1);
    send(1000, 'h8000, 'h4000, "R4 second order step 1");
    send(1000, 'h8000, 'h4000, "R4 second order step 2");
    send(-600, 'h2000, 'h8000, "R4 second order negative");
    send(7, 'h0000, 'h7FFF, "R4 integral only");
    drain();

    // R9 hold between strobes, inputs ignored without valid
    err = 16'sd9999;
    gain_p = 'hFFFF;
    repeat (5) @(negedge clk);
    check(longint'(corr) == last_corr, "R9 corr holds", corr, last_corr);
    check(corr_valid == 1'b0, "R9 no strobe without valid", corr_valid, 0);

    // R5 / R6 saturation positive then release
    for (int i = 0; i < 12; i++) send(32767, 'hFFFF, 'hFFFF, "R5 R6 positive clamp");
    send(-1, 0, 'h8000, "R5 leave upper limit");
    send(0, 0, 0, "R5 sum held below max");
    drain();
    do_clr(1'b1);
    for (int i = 0; i < 12; i++) send(-32768, 'hFFFF, 'hFFFF, "R5 R6 negative clamp");
    send(1, 0, 'hFFFF, "R5 leave lower limit");
    drain();

    // R7 clr cancels sample presented in same cycle
    do_clr(1'b1);
    send(500, 'h8000, 'h8000, "R7 fresh sum after clr");
    drain();
    err = 16'sd3000;
    err_valid = 1'b1;
    clr = 1'b1;
    @(negedge clk);
    err_valid = 1'b0;
    clr = 1'b0;
    m_acc = 0;
    repeat (3) @(negedge clk);
    check(corr == '0, "R7 cancelled sample leaves zero", corr, 0);
    check(corr_valid == 1'b0, "R7 cancelled sample no strobe", corr_valid, 0);
    send(100, 'h8000, 'h8000, "R7 sum restarts at zero");
    drain();

    // back to first order through clr
    do_clr(1'b0);
    send(-4000, 'hC000, 'hFFFF, "R3 first order after clr");
    drain();
    check(sb_q.size() == 0, "R2 scoreboard empty", sb_q.size(), 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule